// File: doc/BRIEF.md
# Exclusive Pull Resistor Controller

This block holds the pull-up and pull-down enable state for every pin of a 32-pin I/O bank and drives one pull-up enable and one pull-down enable per pin toward the pad drivers. Software changes the state through a simple register-write port made of an address, a 32-bit data word and a write strobe. Each resistor type has a set (enable) register and a clear (disable) register. Writing a 1 to a bit acts on that pin. Writing a 0 to a bit leaves that pin alone. Two status registers report the current state and can be read back on the same address bus.

The block guarantees that no pin ever has both resistors enabled at the same time. A request to enable one resistor type is dropped, pin by pin, wherever the other type is still enabled for that pin. The other pins named in the same write still take the request. The decision uses the state held before the write. To move a pin from pull-up to pull-down, software therefore disables the pull-up in one write and enables the pull-down in a later write.

Pull-resistor control does not depend on which function the pin is currently serving, so the block has no input for pin function.

Top module: `pull_resistor_ctrl`

## Requirements
- R1: After reset the pull-up status reads 0x00000000 and the pull-down status reads 0xFFFFFFFF. At the pads, every pullUpEn bit is 1 and every pullDownEn bit is 0.
- R2: The register map is: address 0x0 enables pull-ups, 0x1 disables pull-ups, 0x2 is pull-up status, 0x4 enables pull-downs, 0x5 disables pull-downs and 0x6 is pull-down status. Status bits are active low: a 0 means the resistor is enabled. A written 1 clears the status bit for an enable and sets it for a disable.
- R3: Each pad enable output is the inverse of its status bit. It is registered and changes at the clock edge that samples the write strobe.
- R4: pullUpEn and pullDownEn are never both 1 for the same pin.
- R5: A pull-down enable is discarded for each pin whose pull-up is enabled before the write. The other written pins are still enabled.
- R6: A pull-up enable is discarded for each pin whose pull-down is enabled before the write. The other written pins are still enabled.
- R7: A 0 bit in the data of any enable or disable write leaves that pin's state unchanged.
- R8: Reads at the four enable and disable addresses return 0. Reads at unmapped addresses also return 0. The read data is combinational from addr.
- R9: With wrEn low, no address or data changes any state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Write strobe |
| addr | input | 4 | Register address for writes and reads |
| wrData | input | 32 | Write data, one bit per pin |
| rdData | output | 32 | Read data for addr |
| pullUpEn | output | 32 | Per-pin pull-up enable to the pads |
| pullDownEn | output | 32 | Per-pin pull-down enable to the pads |

## Verification
The bench goes after words that name some pins whose opposite resistor is enabled and some pins whose opposite resistor is free. A design that dropped the whole write, or accepted it everywhere, would leave the wrong pins changed, and the second case would put both resistors on one pin. It also writes data words with sparse bits and all-zero data, and holds a write word on the bus with the strobe low. A design that acted on 0 bits, or sampled without the strobe, would disturb pins that were never named. Reads of the enable and disable addresses catch a design that echoes status or the last written data there.

// File: rtl/pullctl_pkg.sv
package pullctl_pkg;

  localparam int ADDR_W = 4;

  // Register map; bit 2 of the address picks the resistor type
  localparam logic [ADDR_W-1:0] ADDR_PU_SET  = 4'h0;
  localparam logic [ADDR_W-1:0] ADDR_PU_CLR  = 4'h1;
  localparam logic [ADDR_W-1:0] ADDR_PU_STAT = 4'h2;
  localparam logic [ADDR_W-1:0] ADDR_PD_SET  = 4'h4;
  localparam logic [ADDR_W-1:0] ADDR_PD_CLR  = 4'h5;
  localparam logic [ADDR_W-1:0] ADDR_PD_STAT = 4'h6;

  // Strobes from control to datapath
  typedef struct packed {
    logic upSet;
    logic upClr;
    logic dnSet;
    logic dnClr;
  } wrStrobe_t;

  typedef enum logic [1:0] {
    RD_ZERO = 2'd0,
    RD_UP   = 2'd1,
    RD_DN   = 2'd2
  } rdSel_e;

endpackage

// File: rtl/pull_ctrl_decode.sv
module pull_ctrl_decode
  import pullctl_pkg::*;
(
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  output wrStrobe_t         stb,
  output rdSel_e            rdSel
);

  always_comb begin
    stb = '0;
    if (wrEn) begin
      unique case (addr)
        ADDR_PU_SET: stb.upSet = 1'b1;
        ADDR_PU_CLR: stb.upClr = 1'b1;
        ADDR_PD_SET: stb.dnSet = 1'b1;
        ADDR_PD_CLR: stb.dnClr = 1'b1;
        default:     stb = '0;
      endcase
    end
  end

  always_comb begin
    unique case (addr)
      ADDR_PU_STAT: rdSel = RD_UP;
      ADDR_PD_STAT: rdSel = RD_DN;
      default:      rdSel = RD_ZERO;
    endcase
  end

endmodule

// File: rtl/pull_ctrl_datapath.sv
module pull_ctrl_datapath
  import pullctl_pkg::*;
#(
  parameter int PINS = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  wrStrobe_t       stb,
  input  rdSel_e          rdSel,
  input  logic [PINS-1:0] wrData,
  output logic [PINS-1:0] rdData,
  output logic [PINS-1:0] pullUpEn,
  output logic [PINS-1:0] pullDownEn
);

  // Active-low status: 0 = resistor enabled
  logic [PINS-1:0] upStat, dnStat;
  logic [PINS-1:0] upNext, dnNext;

  for (genvar p = 0; p < PINS; p++) begin : g_pin
    logic upN, dnN;
    always_comb begin
      upN = upStat[p];
      dnN = dnStat[p];
      if (wrData[p]) begin
        if (stb.upClr)                    upN = 1'b1;
        else if (stb.upSet && dnStat[p])  upN = 1'b0;
        if (stb.dnClr)                    dnN = 1'b1;
        else if (stb.dnSet && upStat[p])  dnN = 1'b0;
      end
    end
    assign upNext[p] = upN;
    assign dnNext[p] = dnN;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      upStat     <= '0;
      dnStat     <= '1;
      pullUpEn   <= '1;
      pullDownEn <= '0;
    end else begin
      upStat     <= upNext;
      dnStat     <= dnNext;
      pullUpEn   <= ~upNext;
      pullDownEn <= ~dnNext;
    end
  end

  always_comb begin
    unique case (rdSel)
      RD_UP:   rdData = upStat;
      RD_DN:   rdData = dnStat;
      default: rdData = '0;
    endcase
  end

endmodule

// File: rtl/pull_resistor_ctrl.sv
module pull_resistor_ctrl
  import pullctl_pkg::*;
#(
  parameter int PINS = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [PINS-1:0]   wrData,
  output logic [PINS-1:0]   rdData,
  output logic [PINS-1:0]   pullUpEn,
  output logic [PINS-1:0]   pullDownEn
);

  wrStrobe_t stb;
  rdSel_e    rdSel;

  pull_ctrl_decode u_decode (
    .wrEn  (wrEn),
    .addr  (addr),
    .stb   (stb),
    .rdSel (rdSel)
  );

  pull_ctrl_datapath #(.PINS(PINS)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .rdSel      (rdSel),
    .wrData     (wrData),
    .rdData     (rdData),
    .pullUpEn   (pullUpEn),
    .pullDownEn (pullDownEn)
  );

endmodule

// File: rtl/pull_ctrl_checker.sv
module pull_ctrl_checker
  import pullctl_pkg::*;
#(
  parameter int PINS = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic [PINS-1:0]   wrData,
  input logic [PINS-1:0]   rdData,
  input logic [PINS-1:0]   pullUpEn,
  input logic [PINS-1:0]   pullDownEn
);

  AST_PADS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    (pullUpEn & pullDownEn) == '0); // R4

  AST_UP_STATUS_MIRROR: assert property (@(posedge clk) disable iff (!rstN)
    (addr == ADDR_PU_STAT) |-> (rdData == ~pullUpEn)); // R3

  AST_DN_STATUS_MIRROR: assert property (@(posedge clk) disable iff (!rstN)
    (addr == ADDR_PD_STAT) |-> (rdData == ~pullDownEn)); // R3

  AST_CTRL_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (addr == ADDR_PU_SET || addr == ADDR_PU_CLR ||
     addr == ADDR_PD_SET || addr == ADDR_PD_CLR) |-> (rdData == '0)); // R8

  AST_UP_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == ADDR_PU_CLR) |=> ((pullUpEn & $past(wrData)) == '0)); // R2

  AST_DN_ENABLE_BLOCKED: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == ADDR_PD_SET) |=>
      ((pullDownEn & ~$past(pullDownEn) & $past(pullUpEn)) == '0)); // R5

  AST_UP_ENABLE_BLOCKED: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == ADDR_PU_SET) |=>
      ((pullUpEn & ~$past(pullUpEn) & $past(pullDownEn)) == '0)); // R6

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> ($stable(pullUpEn) && $stable(pullDownEn))); // R9

endmodule

bind pull_resistor_ctrl pull_ctrl_checker #(.PINS(PINS)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .wrEn       (wrEn),
  .addr       (addr),
  .wrData     (wrData),
  .rdData     (rdData),
  .pullUpEn   (pullUpEn),
  .pullDownEn (pullDownEn)
);

// File: tb/test_pull_resistor_ctrl.sv
`timescale 1ns/1ps
module test_pull_resistor_ctrl;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [3:0]  addr = 4'h3;
  logic [31:0] wrData = '0;
  logic [31:0] rdData, pullUpEn, pullDownEn;

  int vecs = 0;
  int miss = 0;
  bit done = 0;

  // Model status, active low
  logic [31:0] mUp, mDn;

  pull_resistor_ctrl i_pull_resistor_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .pullUpEn(pullUpEn), .pullDownEn(pullDownEn)
  );

  always #5 clk = ~clk;

  function automatic logic [31:0] nextUp(logic [31:0] u, logic [31:0] d,
                                         logic [3:0] a, logic [31:0] w);
    if (a == 4'h0) return u & ~(w & d);
    if (a == 4'h1) return u | w;
    return u;
  endfunction

  function automatic logic [31:0] nextDn(logic [31:0] u, logic [31:0] d,
                                         logic [3:0] a, logic [31:0] w);
    if (a == 4'h4) return d & ~(w & u);
    if (a == 4'h5) return d | w;
    return d;
  endfunction

  function automatic logic [31:0] expRead(logic [3:0] a);
    if (a == 4'h2) return mUp;
    if (a == 4'h6) return mDn;
    return 32'h0;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      miss++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic doWrite(logic [3:0] a, logic [31:0] w, logic strobe);
    logic [31:0] u;
    @(negedge clk);
    wrEn = strobe; addr = a; wrData = w;
    @(negedge clk);
    wrEn = 1'b0;
    if (strobe) begin
      u   = nextUp(mUp, mDn, a, w);
      mDn = nextDn(mUp, mDn, a, w);
      mUp = u;
    end
  endtask

  task automatic checkPads(string req);
    check(req, pullUpEn, ~mUp);
    check(req, pullDownEn, ~mDn);
    check("R4", pullUpEn & pullDownEn, 32'h0);
  endtask

  task automatic readReg(string req, logic [3:0] a);
    @(negedge clk);
    addr = a;
    #1;
    check(req, rdData, expRead(a));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miss++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
      $finish;
    end
  end

  initial begin
    logic [3:0] addrPool [6] = '{4'h0, 4'h1, 4'h4, 4'h5, 4'h3, 4'hF};
    void'($urandom(32'd20240617));
    mUp = 32'h0; mDn = 32'hFFFF_FFFF;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check("R1", pullUpEn, 32'hFFFF_FFFF);
    check("R1", pullDownEn, 32'h0);
    readReg("R1", 4'h2);
    readReg("R1", 4'h6);
    @(negedge clk) rstN = 1'b1;

    // R5: pull-down enable while every pull-up is on -> all dropped
    doWrite(4'h4, 32'hFFFF_FFFF, 1'b1);
    checkPads("R5");
    // R2: disable pull-ups on pins 0..7
    doWrite(4'h1, 32'h0000_00FF, 1'b1);
    checkPads("R2");
    readReg("R2", 4'h2);
    // R5: mixed word, only pins 0..7 accept
    doWrite(4'h4, 32'h0000_FFFF, 1'b1);
    checkPads("R5");
    check("R5", pullDownEn, 32'h0000_00FF);
    readReg("R2", 4'h6);
    // R6: pull-up enable on pins 0..15, pins 0..7 dropped
    doWrite(4'h1, 32'h0000_FF00, 1'b1);
    doWrite(4'h0, 32'h0000_FFFF, 1'b1);
    checkPads("R6");
    check("R6", pullUpEn, 32'hFFFF_FF00);
    // R7: zero data does nothing
    doWrite(4'h5, 32'h0, 1'b1);
    doWrite(4'h1, 32'h0, 1'b1);
    checkPads("R7");
    // R9: strobe low with live data
    doWrite(4'h5, 32'hFFFF_FFFF, 1'b0);
    checkPads("R9");
    doWrite(4'h1, 32'hFFFF_FFFF, 1'b0);
    checkPads("R9");
    // R8: control addresses read zero
    readReg("R8", 4'h0);
    readReg("R8", 4'h1);
    readReg("R8", 4'h4);
    readReg("R8", 4'h5);
    readReg("R8", 4'hF);
    // R3: pads change at the sampling edge
    @(negedge clk);
    wrEn = 1'b1; addr = 4'h5; wrData = 32'h0000_0001;
    @(posedge clk); #1;
    check("R3", pullDownEn, 32'h0000_00FF & ~32'h0000_0001);
    @(negedge clk) wrEn = 1'b0;
    mDn = mDn | 32'h1;

    // Random mix
    for (int i = 0; i < 400; i++) begin
      logic [3:0]  a;
      logic [31:0] w;
      a = addrPool[$urandom_range(5, 0)];
      case ($urandom_range(2, 0))
        0: w = $urandom();
        1: w = $urandom() & $urandom() & $urandom();
        default: w = 32'h1 << $urandom_range(31, 0);
      endcase
      doWrite(a, w, ($urandom_range(7, 0) != 0));
      checkPads((a[2]) ? "R5" : "R6");
      if ((i % 8) == 0) begin
        readReg("R2", 4'h2);
        readReg("R2", 4'h6);
        readReg("R8", addrPool[$urandom_range(3, 0)]);
      end
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end

endmodule